// File: doc/BRIEF.md
# CAN Receive Acceptance Mask Bank

This block holds the per-filter acceptance masks of a CAN receive path: 64 words of 32 bits each. The host reaches them through a simple request/acknowledge port. Two controller mode inputs gate every access. One input reports that the controller is halted for configuration. The other is a compatibility enable that must be set before the bank may be touched at all. An access that the compatibility enable forbids is answered with an error pulse. An access made while the controller is running is acknowledged, but its write is dropped and its read data is zero.

The identifier matcher fetches masks through a separate lookup port. It names a target kind, either a receive FIFO filter element or a regular message buffer, together with an index. The answer comes back one clock later. The FIFO enable input decides which targets exist. With the FIFO off, every mask belongs to the message buffer with the same number. With the FIFO on, the lowest eight masks belong to the eight filter elements, and message buffers start at number eight. A lookup that names a target that does not exist is flagged, and its mask is returned as all ones.

A combinational helper compares a received identifier with a filter identifier under a given mask. The mask storage has no reset, so software must write every entry before reception begins.

The host sequencer has five states. HS_IDLE waits for a request. On a request it moves to one of four states. It goes to HS_DENIED when the compatibility enable is clear. Otherwise it goes to HS_BLOCKED when the controller is not halted. Otherwise it goes to HS_WR_DONE for a write or HS_RD_DONE for a read. Each of those four states acknowledges for one cycle and always returns to HS_IDLE.

Top module: `can_mask_bank`

## Requirements
- R1: While `legacy_ok`=1 and `freeze_mode`=1, a host write to index 0..63 stores the 32-bit word. A later host read of that index returns it on `host_rdata` with `host_err`=0.
- R2: A request seen in the idle state is acknowledged by a single-cycle `host_ack` on the next clock. A request still present during that acknowledge cycle is ignored.
- R3: While `legacy_ok`=1 and `freeze_mode`=0, a host write leaves the stored word unchanged, and a host read returns 0. Both are acknowledged with `host_err`=0.
- R4: While `legacy_ok`=0, any host access is acknowledged with `host_err`=1, whatever the value of `freeze_mode`. The access writes nothing and returns 0.
- R5: A lookup request (`lk_req`=1) gives `lk_valid`=1 with its result on the next clock only. Without a request, `lk_valid` is 0.
- R6: With `fifo_en`=0, a message-buffer lookup (`lk_tgt_fifo`=0) of index n returns mask n.
- R7: With `fifo_en`=1, a FIFO-element lookup (`lk_tgt_fifo`=1) of index 0..7 returns mask of that index. A message-buffer lookup of index 8..63 returns mask of that index.
- R8: A lookup is invalid in three cases: a FIFO-element lookup with `fifo_en`=0, a FIFO-element lookup of index 8 or above, or a message-buffer lookup of index 0..7 with `fifo_en`=1. An invalid lookup sets `lk_invalid`=1 and returns `lk_mask`=all ones.
- R9: `cmp_hit`=1 exactly when every bit set in `cmp_mask` has equal values in `cmp_rx_id` and `cmp_flt_id`. Bits where the mask is 0 are don't care.
- R10: Reset does not alter stored masks. A word written before a reset pulse reads back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of control state (not the masks) |
| freeze_mode | input | 1 | Controller halted for configuration |
| legacy_ok | input | 1 | Compatibility enable; 0 makes host accesses error |
| fifo_en | input | 1 | Receive FIFO enabled |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_idx | input | 6 | Mask index |
| host_wdata | input | 32 | Write data |
| host_ack | output | 1 | One-cycle access acknowledge |
| host_err | output | 1 | Access error, with acknowledge |
| host_rdata | output | 32 | Read data, valid with acknowledge |
| lk_req | input | 1 | Lookup request |
| lk_tgt_fifo | input | 1 | 1 = FIFO filter element, 0 = message buffer |
| lk_idx | input | 6 | Target index |
| lk_valid | output | 1 | Lookup result valid |
| lk_invalid | output | 1 | Lookup named a nonexistent target |
| lk_mask | output | 32 | Looked-up mask (all ones when invalid, zero when not valid) |
| cmp_rx_id | input | 32 | Received identifier |
| cmp_flt_id | input | 32 | Filter identifier |
| cmp_mask | input | 32 | Mask for comparison |
| cmp_hit | output | 1 | Masked match result |

## Verification
Host results are due one clock after the edge that samples the request. Lookup results are likewise due one clock after their request, and the compare result is due in the same cycle. The bench drives every input on the falling edge. A behavioural model, built from arrays and updated on each rising edge, predicts the acknowledge, the error flag, the read data and the lookup outputs. The bench compares these with the design at every falling edge. Directed checks sample the design at the falling edge after a request, which is exactly where the one-cycle latency places the answer.

// File: rtl/can_mask_pkg.sv
package can_mask_pkg;

    typedef enum logic [2:0] {
        HS_IDLE    = 3'd0,
        HS_RD_DONE = 3'd1,
        HS_WR_DONE = 3'd2,
        HS_BLOCKED = 3'd3,
        HS_DENIED  = 3'd4
    } host_state_e;

    typedef enum logic {
        TGT_MSGBUF = 1'b0,
        TGT_FIFO   = 1'b1
    } lk_target_e;

endpackage

// File: rtl/can_mask_store.sv
// Mask RAM: one write port, two registered read ports, no reset on contents.
module can_mask_store #(
    parameter int N_MASKS = 64,
    parameter int MASK_W  = 32,
    localparam int IDX_W  = $clog2(N_MASKS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [MASK_W-1:0] wr_data,
    input  logic              ra_en,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [MASK_W-1:0] ra_data,
    input  logic              rb_en,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [MASK_W-1:0] rb_data
);

    logic [MASK_W-1:0] words [N_MASKS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (ra_en) begin
            ra_data <= words[ra_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rb_en) begin
            rb_data <= words[rb_idx];
        end
    end

endmodule

// File: rtl/can_mask_host_fsm.sv
// Host access sequencer: decides the outcome of each request and acknowledges it.
module can_mask_host_fsm #(
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              freeze_mode,
    input  logic              legacy_ok,
    input  logic [MASK_W-1:0] mem_rdata,
    output logic              mem_wr_en,
    output logic              mem_rd_en,
    output logic              ack,
    output logic              err,
    output logic [MASK_W-1:0] rdata
);
    import can_mask_pkg::*;

    host_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: compatibility check outranks the freeze check.
    always_comb begin
        state_d = HS_IDLE;
        unique case (state_q)
            HS_IDLE: begin
                if (req) begin
                    if (!legacy_ok)        state_d = HS_DENIED;
                    else if (!freeze_mode) state_d = HS_BLOCKED;
                    else if (we)           state_d = HS_WR_DONE;
                    else                   state_d = HS_RD_DONE;
                end
            end
            HS_RD_DONE, HS_WR_DONE, HS_BLOCKED, HS_DENIED: state_d = HS_IDLE;
            default: state_d = HS_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        ack       = 1'b0;
        err       = 1'b0;
        rdata     = '0;
        mem_wr_en = 1'b0;
        mem_rd_en = 1'b0;
        unique case (state_q)
            HS_IDLE: begin
                mem_wr_en = req & legacy_ok & freeze_mode & we;
                mem_rd_en = req & legacy_ok & freeze_mode & ~we;
            end
            HS_RD_DONE: begin
                ack   = 1'b1;
                rdata = mem_rdata;
            end
            HS_WR_DONE, HS_BLOCKED: ack = 1'b1;
            HS_DENIED: begin
                ack = 1'b1;
                err = 1'b1;
            end
            default: ack = 1'b0;
        endcase
    end

endmodule

// File: rtl/can_mask_lookup.sv
// Lookup mapper: validates the target against the FIFO mode and fetches its mask.
module can_mask_lookup #(
    parameter int N_MASKS    = 64,
    parameter int MASK_W     = 32,
    parameter int FIFO_ELEMS = 8,
    localparam int IDX_W     = $clog2(N_MASKS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  can_mask_pkg::lk_target_e tgt,
    input  logic [IDX_W-1:0]        idx,
    input  logic                    fifo_en,
    input  logic [MASK_W-1:0]       mem_rdata,
    output logic                    mem_rd_en,
    output logic [IDX_W-1:0]        mem_rd_idx,
    output logic                    valid,
    output logic                    invalid,
    output logic [MASK_W-1:0]       mask
);
    import can_mask_pkg::*;

    localparam logic [IDX_W-1:0] FIFO_LIM = IDX_W'(FIFO_ELEMS);

    logic bad;
    logic valid_q, invalid_q;

    always_comb begin
        bad = 1'b0;
        unique case (tgt)
            TGT_FIFO:   bad = !fifo_en || (idx >= FIFO_LIM);
            TGT_MSGBUF: bad = fifo_en && (idx < FIFO_LIM);
            default:    bad = 1'b1;
        endcase
    end

    // Both targets address the mask with their own index; only legality differs.
    assign mem_rd_en  = req & ~bad;
    assign mem_rd_idx = idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            invalid_q <= 1'b0;
        end else begin
            valid_q   <= req;
            invalid_q <= req & bad;
        end
    end

    assign valid   = valid_q;
    assign invalid = invalid_q;
    assign mask    = !valid_q ? '0 : (invalid_q ? '1 : mem_rdata);

endmodule

// File: rtl/can_mask_match.sv
// Masked identifier comparison: mask bit 1 = must match.
module can_mask_match #(
    parameter int MASK_W = 32
) (
    input  logic [MASK_W-1:0] rx_id,
    input  logic [MASK_W-1:0] flt_id,
    input  logic [MASK_W-1:0] mask,
    output logic              hit
);
    assign hit = ~|((rx_id ^ flt_id) & mask);
endmodule

// File: rtl/can_mask_bank.sv
module can_mask_bank #(
    parameter int N_MASKS    = 64,
    parameter int MASK_W     = 32,
    parameter int FIFO_ELEMS = 8,
    localparam int IDX_W     = $clog2(N_MASKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze_mode,
    input  logic              legacy_ok,
    input  logic              fifo_en,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [MASK_W-1:0] host_wdata,
    output logic              host_ack,
    output logic              host_err,
    output logic [MASK_W-1:0] host_rdata,
    input  logic              lk_req,
    input  logic              lk_tgt_fifo,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_valid,
    output logic              lk_invalid,
    output logic [MASK_W-1:0] lk_mask,
    input  logic [MASK_W-1:0] cmp_rx_id,
    input  logic [MASK_W-1:0] cmp_flt_id,
    input  logic [MASK_W-1:0] cmp_mask,
    output logic              cmp_hit
);
    import can_mask_pkg::*;

    logic              wr_en, ra_en, rb_en;
    logic [MASK_W-1:0] ra_data, rb_data;
    logic [IDX_W-1:0]  rb_idx;

    can_mask_host_fsm #(.MASK_W(MASK_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (host_req),
        .we         (host_we),
        .freeze_mode(freeze_mode),
        .legacy_ok  (legacy_ok),
        .mem_rdata  (ra_data),
        .mem_wr_en  (wr_en),
        .mem_rd_en  (ra_en),
        .ack        (host_ack),
        .err        (host_err),
        .rdata      (host_rdata)
    );

    can_mask_lookup #(
        .N_MASKS(N_MASKS), .MASK_W(MASK_W), .FIFO_ELEMS(FIFO_ELEMS)
    ) u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (lk_req),
        .tgt       (lk_target_e'(lk_tgt_fifo)),
        .idx       (lk_idx),
        .fifo_en   (fifo_en),
        .mem_rdata (rb_data),
        .mem_rd_en (rb_en),
        .mem_rd_idx(rb_idx),
        .valid     (lk_valid),
        .invalid   (lk_invalid),
        .mask      (lk_mask)
    );

    can_mask_store #(.N_MASKS(N_MASKS), .MASK_W(MASK_W)) u_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (host_idx),
        .wr_data(host_wdata),
        .ra_en  (ra_en),
        .ra_idx (host_idx),
        .ra_data(ra_data),
        .rb_en  (rb_en),
        .rb_idx (rb_idx),
        .rb_data(rb_data)
    );

    can_mask_match #(.MASK_W(MASK_W)) u_match (
        .rx_id (cmp_rx_id),
        .flt_id(cmp_flt_id),
        .mask  (cmp_mask),
        .hit   (cmp_hit)
    );

endmodule

// File: rtl/can_mask_bank_chk.sv
module can_mask_bank_chk #(
    parameter int MASK_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              freeze_mode,
    input logic              legacy_ok,
    input logic              fifo_en,
    input logic              host_req,
    input logic              host_ack,
    input logic              host_err,
    input logic [MASK_W-1:0] host_rdata,
    input logic              lk_req,
    input logic              lk_tgt_fifo,
    input logic              lk_valid,
    input logic              lk_invalid,
    input logic [MASK_W-1:0] lk_mask,
    input logic [MASK_W-1:0] cmp_mask,
    input logic              cmp_hit
);

    p_ack_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_ack) |=> host_ack);

    p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    p_blocked_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !host_err && !$past(freeze_mode)) |-> (host_rdata == '0));

    p_err_with_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> (host_ack && host_rdata == '0));

    p_legacy_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_ack && !legacy_ok) |=> host_err);

    p_lk_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_valid);

    p_lk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_valid);

    p_invalid_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_invalid |-> (lk_valid && lk_mask == '1));

    p_fifo_off_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_tgt_fifo && !fifo_en) |=> lk_invalid);

    p_empty_mask_hits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_mask == '0) |-> cmp_hit);

endmodule

bind can_mask_bank can_mask_bank_chk #(.MASK_W(MASK_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .freeze_mode(freeze_mode),
    .legacy_ok  (legacy_ok),
    .fifo_en    (fifo_en),
    .host_req   (host_req),
    .host_ack   (host_ack),
    .host_err   (host_err),
    .host_rdata (host_rdata),
    .lk_req     (lk_req),
    .lk_tgt_fifo(lk_tgt_fifo),
    .lk_valid   (lk_valid),
    .lk_invalid (lk_invalid),
    .lk_mask    (lk_mask),
    .cmp_mask   (cmp_mask),
    .cmp_hit    (cmp_hit)
);

// File: tb/test_can_mask_bank.sv
`timescale 1ns/1ps
module test_can_mask_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freeze_mode = 1'b1, legacy_ok = 1'b1, fifo_en = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [5:0]  host_idx = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ack, host_err;
    logic [31:0] host_rdata;
    logic        lk_req = 1'b0, lk_tgt_fifo = 1'b0;
    logic [5:0]  lk_idx = '0;
    logic        lk_valid, lk_invalid;
    logic [31:0] lk_mask;
    logic [31:0] cmp_rx_id = '0, cmp_flt_id = '0, cmp_mask = '0;
    logic        cmp_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit cmp_on = 0;

    always #10 clk = ~clk;

    can_mask_bank i_can_mask_bank (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'h5A3C_0000 ^ (32'(i) * 32'h0101_0307);
    endfunction

    // Behavioural reference model, stepped on each rising edge.
    logic [31:0] m_mem [64];
    logic        m_ack = 0, m_err = 0, m_lkv = 0, m_lki = 0;
    logic [31:0] m_rd = 0, m_lkm = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ack <= 0; m_err <= 0; m_rd <= 0; m_lkv <= 0; m_lki <= 0; m_lkm <= 0;
        end else begin
            m_err <= 0; m_rd <= 0;
            if (host_req && !m_ack) begin
                m_ack <= 1;
                if (!legacy_ok) m_err <= 1;
                else if (freeze_mode) begin
                    if (host_we) m_mem[host_idx] <= host_wdata;
                    else         m_rd <= m_mem[host_idx];
                end
            end else begin
                m_ack <= 0;
            end
            m_lkv <= lk_req;
            if (!lk_req) begin
                m_lki <= 0; m_lkm <= 0;
            end else if ((lk_tgt_fifo && (!fifo_en || lk_idx > 7)) ||
                         (!lk_tgt_fifo && fifo_en && lk_idx < 8)) begin
                m_lki <= 1; m_lkm <= 32'hFFFF_FFFF;
            end else begin
                m_lki <= 0; m_lkm <= m_mem[lk_idx];
            end
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R2 model ack", {31'b0, host_ack}, {31'b0, m_ack});
            chk("R4 model err", {31'b0, host_err}, {31'b0, m_err});
            chk("R1 model rdata", host_rdata, m_rd);
            chk("R5 model lk_valid", {31'b0, lk_valid}, {31'b0, m_lkv});
            chk("R8 model lk_invalid", {31'b0, lk_invalid}, {31'b0, m_lki});
            chk("R6 model lk_mask", lk_mask, m_lkm);
        end
    end

    task automatic host_op(input logic we, input int idx, input logic [31:0] d);
        @(negedge clk);
        host_req = 1; host_we = we; host_idx = 6'(idx); host_wdata = d;
        @(negedge clk);
        host_req = 0; host_we = 0;
    endtask

    task automatic lookup(input logic fifo, input int idx);
        @(negedge clk);
        lk_req = 1; lk_tgt_fifo = fifo; lk_idx = 6'(idx);
        @(negedge clk);
        lk_req = 0;
    endtask

    function automatic logic exp_hit(input logic [31:0] a, b, m);
        for (int k = 0; k < 32; k++) if (m[k] && (a[k] != b[k])) return 0;
        return 1;
    endfunction

    task automatic cmp_case(input logic [31:0] a, b, m);
        cmp_rx_id = a; cmp_flt_id = b; cmp_mask = m;
        #1;
        chk("R9 masked compare", {31'b0, cmp_hit}, {31'b0, exp_hit(a, b, m)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1;
        chk("R2 reset ack", {31'b0, host_ack}, 32'd0);
        chk("R5 reset lk_valid", {31'b0, lk_valid}, 32'd0);
        @(negedge clk); rst_n = 1;

        for (int i = 0; i < 64; i++) host_op(1, i, pat(i));
        host_op(0, 0, 0);  chk("R1 read idx0", host_rdata, pat(0));
        host_op(0, 37, 0); chk("R1 read idx37", host_rdata, pat(37));
        host_op(0, 63, 0); chk("R1 read idx63", host_rdata, pat(63));

        // R2: request held across the acknowledge cycle is ignored.
        @(negedge clk); host_req = 1; host_we = 0; host_idx = 6'd9;
        @(negedge clk); chk("R2 ack after req", {31'b0, host_ack}, 32'd1);
        @(negedge clk); host_req = 0;
        chk("R2 held req ignored", {31'b0, host_ack}, 32'd0);

        // R3: not frozen.
        freeze_mode = 0;
        host_op(1, 5, 32'hDEAD_BEEF);
        chk("R3 blocked write err", {31'b0, host_err}, 32'd0);
        host_op(0, 5, 0);
        chk("R3 blocked read zero", host_rdata, 32'd0);
        chk("R3 blocked read ack", {31'b0, host_ack}, 32'd1);
        freeze_mode = 1;
        host_op(0, 5, 0); chk("R3 write discarded", host_rdata, pat(5));

        // R4: compatibility bit clear, both freeze settings.
        legacy_ok = 0;
        host_op(1, 6, 32'h1234_5678);
        chk("R4 write error", {31'b0, host_err}, 32'd1);
        freeze_mode = 0;
        host_op(0, 6, 0);
        chk("R4 precedence error", {31'b0, host_err}, 32'd1);
        chk("R4 error data zero", host_rdata, 32'd0);
        freeze_mode = 1; legacy_ok = 1;
        @(negedge clk);
        chk("R4 err one cycle", {31'b0, host_err}, 32'd0);
        host_op(0, 6, 0); chk("R4 no write", host_rdata, pat(6));

        // Lookups, FIFO off.
        fifo_en = 0;
        lookup(0, 3);
        chk("R5 lk_valid", {31'b0, lk_valid}, 32'd1);
        chk("R6 msgbuf3", lk_mask, pat(3));
        @(negedge clk); chk("R5 lk_valid drops", {31'b0, lk_valid}, 32'd0);
        lookup(1, 2);
        chk("R8 fifo while off", {31'b0, lk_invalid}, 32'd1);
        chk("R8 ones mask", lk_mask, 32'hFFFF_FFFF);

        // Lookups, FIFO on.
        fifo_en = 1;
        lookup(1, 2);  chk("R7 fifo elem2", lk_mask, pat(2));
        lookup(1, 7);  chk("R7 fifo elem7", lk_mask, pat(7));
        lookup(0, 40); chk("R7 msgbuf40", lk_mask, pat(40));
        lookup(0, 8);  chk("R7 msgbuf8", lk_mask, pat(8));
        lookup(0, 4);  chk("R8 low msgbuf", {31'b0, lk_invalid}, 32'd1);
        lookup(1, 9);  chk("R8 fifo idx9", lk_mask, 32'hFFFF_FFFF);
        fifo_en = 0;

        // R9 compare helper.
        cmp_case(32'h0000_1234, 32'h0000_1234, 32'hFFFF_FFFF);
        cmp_case(32'h0000_1235, 32'h0000_1234, 32'hFFFF_FFFF);
        cmp_case(32'h0000_1235, 32'h0000_1234, 32'hFFFF_FFFE);
        cmp_case(32'hFFFF_0000, 32'h0000_FFFF, 32'h0000_0000);
        cmp_case(32'h8000_0000, 32'h0000_0000, 32'h8000_0000);

        // R10: contents survive reset.
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        host_op(0, 37, 0); chk("R10 kept after reset", host_rdata, pat(37));

        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule